// File: doc/BRIEF.md
# Serial Register Access Port with Pipelined Replies

This block is a serial-peripheral slave that gives a host controller access to a small set of 11-bit registers. Two addresses are read-only and mirror status flags that other logic supplies. Two are read/write configuration registers whose contents drive the block's outputs. Every transaction is one 16-bit word, and the serial clock idles low. The slave reads the word in on falling clock edges and shifts its reply out on rising edges, most significant bit first.

Replies are pipelined. The word returned during a transaction answers the command sent in the transaction before it. A read returns the addressed register with its address echoed. A write returns the first status register. A malformed transaction is thrown away, and its slot in the next reply carries only a fault marker. One bit of the first configuration register is a command rather than a setting: writing a 1 to it emits a single-cycle pulse, and the bit always reads back as 0.

All serial pins are brought into the system clock domain through a synchronizer, and edges are found there. The host's clock edges must therefore be at least a few system clock cycles apart. The chip select must also stay deasserted for at least three system clocks between transactions.

Top module: `spi_regbank`

## Requirements
- R1: The command word carries the access type in bit 15 (1 = read, 0 = write), the register address in bits 14:11 and the data in bits 10:0. It is shifted in MSB first.
- R2: After a valid read of address A, the next transaction returns bit 15 = 0, address A in bits 14:11 and the contents of A in bits 10:0.
- R3: After a valid write, and after reset, the next transaction returns bit 15 = 0, address 0 in bits 14:11 and the status-0 input in bits 10:0.
- R4: Addresses 2 and 3 are read/write configuration registers that reset to 0. Writes to addresses 0, 1 and 4 to 15 change nothing. Reads of addresses 4 to 15 return data 0. The configuration outputs change only when a valid transaction completes.
- R5: A transaction is valid only if three conditions hold: SCLK is low when CS_N falls, exactly 16 SCLK falling edges occur, and SCLK is low when CS_N rises. An invalid transaction has no effect on any register, writes included.
- R6: After an invalid transaction, the next reply is exactly 0x8000: fault bit 15 set, all other bits 0.
- R7: The SDO output enable is high only while CS_N is low, and SDO is 0 while the enable is low. SCLK and SDI activity while CS_N is high has no effect.
- R8: Writing address 2 with bit 2 set produces exactly one system-clock pulse on the gate-reset output. Bit 2 of address 2 always reads back, and drives out, as 0.
- R9: Arbitrarily long pauses between SCLK edges inside a transaction do not affect the result.
- R10: The reply bits change only after a rising SCLK edge and are sent MSB first, so the host samples bit 15 at the first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| stat0_in | input | 11 | Status flags shown at address 0 |
| stat1_in | input | 11 | Status flags shown at address 1 |
| ctrl0_out | output | 11 | Configuration register at address 2 |
| ctrl1_out | output | 11 | Configuration register at address 3 |
| gate_rst_pulse | output | 1 | One-cycle pulse from writing bit 2 of address 2 |

## Verification
The checker enforces several properties on every clock:
- the reply line is quiet whenever the output enable is low;
- the reply only moves after a detected rising serial edge;
- the configuration outputs hold still unless a valid transaction has just completed;
- the gate-reset pulse lasts one cycle and follows a completed transaction;
- a transaction is never judged both valid and invalid.

Other behaviour only the bench's transaction sequences can show: the one-transaction lag of the replies, the fault reply that follows short, long and badly framed transactions, the status-0 reply after writes, readback masking of the command bit, and tolerance of long pauses. The bench shows these by comparing each reply against a behavioural model.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  // kind of reply queued for the next transaction
  typedef enum logic [1:0] {
    RSP_STAT0 = 2'd0,
    RSP_READ  = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_pin,
  input  logic sclk_pin,
  input  logic sdi_pin,
  output logic cs_low,
  output logic sclk_lvl,
  output logic sdi_lvl,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b100;

  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] cur;
  logic [1:0]      prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      prev <= 2'b10;
    end else begin
      chain[0] <= {cs_n_pin, sclk_pin, sdi_pin};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= cur[2:1];
    end
  end

  assign cur       = chain[STAGES-1];
  assign cs_low    = ~cur[2];
  assign sclk_lvl  = cur[1];
  assign sdi_lvl   = cur[0];
  assign cs_fall   = ~cur[2] & prev[1];
  assign cs_rise   = cur[2] & ~prev[1];
  assign sclk_rise = ~cur[2] & cur[1] & ~prev[0];
  assign sclk_fall = ~cur[2] & ~cur[1] & prev[0];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_low,
  input  logic              sclk_lvl,
  input  logic              sdi_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              commit_ok,
  output logic              commit_bad,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic              start_ok;
  logic [WORD_W-1:0] tx_sh;
  logic              sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      start_ok   <= 1'b0;
      tx_sh      <= '0;
      rx_word    <= '0;
      sdo_q      <= 1'b0;
      sdo_oe     <= 1'b0;
      commit_ok  <= 1'b0;
      commit_bad <= 1'b0;
    end else begin
      commit_ok  <= 1'b0;
      commit_bad <= 1'b0;
      sdo_oe     <= cs_low;
      if (cs_fall) begin
        start_ok <= ~sclk_lvl;
        cnt      <= '0;
        tx_sh    <= load_word;
        sdo_q    <= 1'b0;
      end else if (cs_rise) begin
        sdo_q <= 1'b0;
        if (start_ok && !sclk_lvl && cnt == CNT_FULL) commit_ok <= 1'b1;
        else                                          commit_bad <= 1'b1;
      end else begin
        if (sclk_rise) begin
          sdo_q <= tx_sh[WORD_W-1];
          tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
        if (sclk_fall) begin
          rx_word <= {rx_word[WORD_W-2:0], sdi_lvl};
          if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sdo = sdo_q & sdo_oe;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regbank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 11,
  parameter int GATE_BIT = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       commit_ok,
  input  logic                       commit_bad,
  input  logic [ADDR_W+DATA_W:0]     rx_word,
  input  logic [DATA_W-1:0]          stat0,
  input  logic [DATA_W-1:0]          stat1,
  output logic [DATA_W-1:0]          ctrl0,
  output logic [DATA_W-1:0]          ctrl1,
  output logic                       gate_pulse,
  output logic [ADDR_W+DATA_W:0]     resp_word
);
  localparam int WORD_W = ADDR_W + DATA_W + 1;
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(3);
  localparam logic [DATA_W-1:0] GATE_MASK = DATA_W'(1) << GATE_BIT;

  logic              is_read;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  rsp_kind_e         kind;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] rd_data;

  assign is_read  = rx_word[WORD_W-1];
  assign cmd_addr = rx_word[WORD_W-2 -: ADDR_W];
  assign cmd_data = rx_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0      <= '0;
      ctrl1      <= '0;
      gate_pulse <= 1'b0;
      kind       <= RSP_STAT0;
      pend_addr  <= '0;
    end else begin
      gate_pulse <= 1'b0;
      if (commit_bad) begin
        kind <= RSP_FAULT;
      end else if (commit_ok) begin
        if (is_read) begin
          kind      <= RSP_READ;
          pend_addr <= cmd_addr;
        end else begin
          kind <= RSP_STAT0;
          if (cmd_addr == A_CTRL0) begin
            ctrl0      <= cmd_data & ~GATE_MASK;
            gate_pulse <= cmd_data[GATE_BIT];
          end else if (cmd_addr == A_CTRL1) begin
            ctrl1 <= cmd_data;
          end
        end
      end
    end
  end

  always_comb begin
    case (pend_addr)
      A_STAT0: rd_data = stat0;
      A_STAT1: rd_data = stat1;
      A_CTRL0: rd_data = ctrl0;
      A_CTRL1: rd_data = ctrl1;
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    case (kind)
      RSP_FAULT: resp_word = {1'b1, {(WORD_W-1){1'b0}}};
      RSP_READ:  resp_word = {1'b0, pend_addr, rd_data};
      default:   resp_word = {1'b0, A_STAT0, stat0};
    endcase
  end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 11,
  parameter int GATE_BIT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [DATA_W-1:0] stat0_in,
  input  logic [DATA_W-1:0] stat1_in,
  output logic [DATA_W-1:0] ctrl0_out,
  output logic [DATA_W-1:0] ctrl1_out,
  output logic              gate_rst_pulse
);
  localparam int WORD_W = ADDR_W + DATA_W + 1;

  logic cs_low, sclk_lvl, sdi_lvl;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic commit_ok, commit_bad;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] resp_word;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n_pin(cs_n), .sclk_pin(sclk), .sdi_pin(sdi),
    .cs_low(cs_low), .sclk_lvl(sclk_lvl), .sdi_lvl(sdi_lvl),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  spi_frame_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_low(cs_low), .sclk_lvl(sclk_lvl), .sdi_lvl(sdi_lvl),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .load_word(resp_word),
    .sdo(sdo), .sdo_oe(sdo_oe),
    .commit_ok(commit_ok), .commit_bad(commit_bad),
    .rx_word(rx_word)
  );

  spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_regs (
    .clk(clk), .rst(rst),
    .commit_ok(commit_ok), .commit_bad(commit_bad),
    .rx_word(rx_word),
    .stat0(stat0_in), .stat1(stat1_in),
    .ctrl0(ctrl0_out), .ctrl1(ctrl1_out),
    .gate_pulse(gate_rst_pulse),
    .resp_word(resp_word)
  );
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int DATA_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              gate_pulse,
  input logic [DATA_W-1:0] ctrl0,
  input logic [DATA_W-1:0] ctrl1,
  input logic              commit_ok,
  input logic              commit_bad,
  input logic              rise_det
);
  assert_sdo_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

  assert_sdo_moves_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && !$past(rise_det)) |-> $stable(sdo));

  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !commit_ok |=> ($stable(ctrl0) && $stable(ctrl1)));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    gate_pulse |=> !gate_pulse);

  assert_pulse_after_commit_R8: assert property (@(posedge clk) disable iff (rst)
    gate_pulse |-> $past(commit_ok));

  assert_verdict_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(commit_ok && commit_bad));
endmodule

bind spi_regbank spi_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sdo(sdo), .sdo_oe(sdo_oe),
  .gate_pulse(gate_rst_pulse), .ctrl0(ctrl0_out), .ctrl1(ctrl1_out),
  .commit_ok(commit_ok), .commit_bad(commit_bad), .rise_det(sclk_rise)
);

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [10:0] stat0 = 11'h5A3;
  logic [10:0] stat1 = 11'h40F;
  logic sdo, sdo_oe, gp;
  logic [10:0] ctrl0, ctrl1;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int e_pulses = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  logic [10:0] e_ctrl0 = '0;
  logic [10:0] e_ctrl1 = '0;
  logic [15:0] exp_rsp;
  string exp_tag = "R3";

  always #10 clk = ~clk;

  spi_regbank u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .stat0_in(stat0), .stat1_in(stat1),
    .ctrl0_out(ctrl0), .ctrl1_out(ctrl1), .gate_rst_pulse(gp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (gp === 1'b1) pulses++;
      if (cmp_on) begin
        check("R4 ctrl0 per-clock", ctrl0, e_ctrl0);
        check("R4 ctrl1 per-clock", ctrl1, e_ctrl1);
        if (sdo_oe === 1'b0) check("R7 sdo idle", sdo, 1'b0);
      end
    end
  end

  function automatic logic [10:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return stat0;
      4'd1: return stat1;
      4'd2: return e_ctrl0;
      4'd3: return e_ctrl1;
      default: return 11'h000;
    endcase
  endfunction

  task automatic xfer(input logic [15:0] word, input int nbits, input bit hi_start,
                      input bit hi_end, input int gap);
    logic [15:0] got;
    logic [3:0] a;
    bit valid;
    got = '0;
    if (hi_start) begin sclk = 1'b1; wclk(6); end
    cs_n = 1'b0;
    wclk(6);
    check("R7 oe during frame", sdo_oe, 1'b1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      sdi = (i < 16) ? word[15-i] : 1'b1;
      wclk((i == 5) ? gap : 6);
      if (i < 16) got = {got[14:0], sdo};
      sclk = 1'b0;
      wclk(6);
    end
    if (hi_end) begin sclk = 1'b1; wclk(6); end
    cmp_on = 1'b0;
    cs_n = 1'b1;
    wclk(8);
    check("R7 oe after frame", sdo_oe, 1'b0);
    // noise while deselected must be ignored
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; sdi = ~sdi; wclk(5);
      sclk = 1'b0; wclk(5);
    end
    valid = (nbits == 16) && !hi_start && !hi_end;
    if (nbits >= 16 && !hi_start)
      check({exp_tag, "/R10 reply"}, got, exp_rsp);
    a = word[14:11];
    if (!valid) begin
      exp_rsp = 16'h8000;
      exp_tag = "R6";
    end else if (word[15]) begin
      exp_rsp = {1'b0, a, model_rd(a)};
      exp_tag = (a > 4'd3) ? "R4" : "R2";
    end else begin
      exp_rsp = {1'b0, 4'h0, stat0};
      exp_tag = "R3";
      if (a == 4'd2) begin
        e_ctrl0 = word[10:0] & ~11'h004;
        if (word[2]) e_pulses++;
      end else if (a == 4'd3) begin
        e_ctrl1 = word[10:0];
      end
    end
    cmp_on = 1'b1;
    wclk(2);
    check("R8 pulse count", pulses, e_pulses);
  endtask

  function automatic logic [15:0] rd(input int a);
    return {1'b1, 4'(a), 11'h000};
  endfunction

  function automatic logic [15:0] wr(input int a, input logic [10:0] d);
    return {1'b0, 4'(a), d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_rsp = {1'b0, 4'h0, stat0};
    wclk(5);
    check("R4 ctrl0 reset", ctrl0, 11'h0);
    check("R4 ctrl1 reset", ctrl1, 11'h0);
    check("R8 pulse low at reset", gp, 1'b0);
    check("R7 oe low at reset", sdo_oe, 1'b0);
    rst = 1'b0;
    wclk(4);
    cmp_on = 1'b1;

    xfer(rd(0), 16, 0, 0, 6);              // reply after reset: status 0 (R3)
    xfer(wr(2, 11'h7FF), 16, 0, 0, 6);     // R1 write, R8 pulse, bit 2 masked
    xfer(rd(2), 16, 0, 0, 6);              // write reply = status 0 (R3)
    xfer(rd(3), 16, 0, 0, 6);              // R8 readback 0x7FB
    xfer(wr(3, 11'h2A5), 16, 0, 0, 6);
    xfer(rd(1), 16, 0, 0, 6);
    xfer(wr(0, 11'h7FF), 16, 0, 0, 6);     // R4 write to status ignored
    xfer(rd(0), 16, 0, 0, 6);
    xfer(rd(9), 16, 0, 0, 6);              // R4 unmapped
    xfer(rd(3), 16, 0, 0, 6);
    xfer(wr(3, 11'h000), 12, 0, 0, 6);     // R5 short frame discarded
    xfer(rd(3), 16, 0, 0, 6);              // R6 fault reply
    xfer(wr(2, 11'h000), 18, 0, 0, 6);     // R5 long frame discarded
    xfer(wr(3, 11'h000), 16, 1, 0, 6);     // R5 SCLK high at select
    xfer(rd(2), 16, 0, 0, 6);
    xfer(wr(2, 11'h000), 16, 0, 1, 6);     // R5 SCLK high at deselect
    xfer(rd(3), 16, 0, 0, 60);             // R9 long pause
    xfer(wr(2, 11'h004), 16, 0, 0, 45);    // R8 pulse only, R9
    xfer(rd(2), 16, 0, 0, 6);
    xfer(rd(0), 16, 0, 0, 6);
    check("R8 final pulse count", pulses, 2);
    check("R4 final ctrl1", ctrl1, 11'h2A5);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule